// File: doc/BRIEF.md
# Multi-Policy Cache Replacement Selector

This block holds the replacement bookkeeping for every set of an N-way set-associative cache and names the way to evict. A cache controller presents a set number each cycle. It reports a hit with a touch strobe and the hit way. It reports a line load with a fill strobe and the loaded way. One clock later the block returns the victim way for that set under the policy selected on the policy input, and also reports per-way observation values and the set's clock pointer.

Six policies share one interface:

- recency ordering, evicting either the least or the most recently used way;
- arrival ordering;
- a saturating use counter;
- a second-chance clock;
- a pseudo-random pick.

All bookkeeping structures are updated on every strobe, whatever the policy. Switching the policy therefore only changes how the stored state is read. The controller decides whether to use a free way or the victim, so the block keeps no valid bits.

Top module: `repl_select`

## Requirements
- R1: Policy code 0 (LRU). Each way holds a recency rank in 0..WAYS-1. A touch or fill of way w sets w's rank to 0 and adds 1 to every way whose rank was below w's old rank. The victim is the way whose rank is WAYS-1.
- R2: Policy code 1 (FIFO). A separate arrival rank is kept with the same update rule, but only fills change it. The victim is the way whose arrival rank is WAYS-1.
- R3: Policy code 2 (MRU). The victim is the way whose recency rank (as in R1) is 0.
- R4: Policy code 3 (LFU). Each way holds a CNT_W-bit use count. A touch adds 1 unless the count is already all ones. A fill sets the count to 1. The victim is the way with the smallest count, with ties going to the lowest way number.
- R5: Policy code 4 (Clock). A touch sets the way's reference bit. The victim is the first way with a clear bit, scanning upward from the set's pointer and wrapping. If every bit is set, the victim is the way under the pointer.
- R6: On a fill of way f, let d(w) = (w - ptr) mod WAYS:
  - If all reference bits were set, all of them are cleared.
  - Otherwise, every way with d(w) < d(f) is cleared.
  - Then f's bit is set and the pointer becomes (f+1) mod WAYS.
- R7: Policy code 5 (Random). The victim is the low log2(WAYS) bits of a 16-bit LFSR. The LFSR holds LFSR_SEED in reset and otherwise shifts left each clock, taking in bit15^bit13^bit12^bit10.
- R8: Outputs are registered. At each edge, victim_o, state_o and ptr_o capture the state of set_idx as it was before that edge's update. state_o field w (bits w*CNT_W up) shows:
  - the recency rank for codes 0, 2, 6 and 7;
  - the arrival rank for code 1;
  - the count for code 3;
  - the reference bit for code 4;
  - zero for code 5.
- R9: When touch and fill are both high, the fill is applied and the touch is ignored. Only the set named by set_idx changes.
- R10: Reset clears all outputs, sets every rank to its way number, clears counts and reference bits, and sets every pointer to way 0.
- R11: State tracks all policies at all times, so a policy change takes effect on the next edge without losing history. Codes 6 and 7 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 3 | Policy code (0 LRU, 1 FIFO, 2 MRU, 3 LFU, 4 Clock, 5 Random) |
| set_idx | input | log2(SETS) | Set being read and updated |
| touch | input | 1 | Hit report strobe |
| touch_way | input | log2(WAYS) | Way that hit |
| fill | input | 1 | Line load strobe |
| fill_way | input | log2(WAYS) | Way that was loaded |
| victim_o | output | log2(WAYS) | Registered victim way |
| state_o | output | WAYS*CNT_W | Registered per-way observation fields |
| ptr_o | output | log2(WAYS) | Registered clock pointer of the set |

## Verification
The bench keeps its own model of every set and drives long pseudo-random streams of touches, fills and simultaneous strobes under each policy code, including switches between policies without a reset. It compares victim, fields and pointer every cycle.

It targets the corner cases that a plausible bug would get wrong:

- LFU counts pinned at saturation: a wrapping counter would turn the busiest way into the victim.
- Equal LFU counts: picking the highest way instead of the lowest would be caught.
- A clock sweep with every bit set: a design that failed to clear the bits would stall the pointer or name the wrong way.
- Simultaneous touch and fill: letting the touch win would leave a stale rank.
- The LFSR sequence from its seed: any mismatch in the taps or the seed would show up at once as a different random victim.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum logic [2:0] {
    POL_LRU   = 3'd0,
    POL_FIFO  = 3'd1,
    POL_MRU   = 3'd2,
    POL_LFU   = 3'd3,
    POL_CLOCK = 3'd4,
    POL_RAND  = 3'd5
  } repl_pol_e;
endpackage

// File: rtl/repl_rank_store.sv
// Per-set rank table: an update moves the chosen way to rank 0 and ages
// every way that was younger than it.
module repl_rank_store #(
  parameter int WAYS = 4,
  parameter int SETS = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [$clog2(SETS)-1:0]         set_idx,
  input  logic                            upd,
  input  logic [$clog2(WAYS)-1:0]         upd_way,
  output logic [WAYS*$clog2(WAYS)-1:0]    row_o,
  output logic [$clog2(WAYS)-1:0]         oldest_o,
  output logic [$clog2(WAYS)-1:0]         newest_o
);
  localparam int RW = $clog2(WAYS);
  localparam logic [RW-1:0] TOP = RW'(WAYS - 1);

  logic [WAYS*RW-1:0] mem [SETS];
  logic [WAYS*RW-1:0] nxt;
  logic [RW-1:0]      tgt;

  assign row_o = mem[set_idx];
  assign tgt   = row_o[upd_way*RW +: RW];

  always_comb begin
    nxt = row_o;
    for (int w = 0; w < WAYS; w++) begin
      if (RW'(w) == upd_way)
        nxt[w*RW +: RW] = '0;
      else if (row_o[w*RW +: RW] < tgt)
        nxt[w*RW +: RW] = row_o[w*RW +: RW] + 1'b1;
    end
  end

  always_comb begin
    oldest_o = '0;
    newest_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (row_o[w*RW +: RW] == TOP) oldest_o = RW'(w);
      if (row_o[w*RW +: RW] == '0)  newest_o = RW'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          mem[s][w*RW +: RW] <= RW'(w);
    end else if (upd) begin
      mem[set_idx] <= nxt;
    end
  end
endmodule

// File: rtl/repl_lfu_store.sv
// Per-set saturating use counters with lowest-count victim search.
module repl_lfu_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int CNT_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(SETS)-1:0]     set_idx,
  input  logic                        touch,
  input  logic [$clog2(WAYS)-1:0]     touch_way,
  input  logic                        fill,
  input  logic [$clog2(WAYS)-1:0]     fill_way,
  output logic [WAYS*CNT_W-1:0]       row_o,
  output logic [$clog2(WAYS)-1:0]     victim_o
);
  localparam int RW = $clog2(WAYS);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [WAYS*CNT_W-1:0] mem [SETS];
  logic [WAYS*CNT_W-1:0] nxt;
  logic [CNT_W-1:0]      best_c;

  assign row_o = mem[set_idx];

  always_comb begin
    nxt = row_o;
    if (fill)
      nxt[fill_way*CNT_W +: CNT_W] = CNT_W'(1);
    else if (touch && row_o[touch_way*CNT_W +: CNT_W] != CMAX)
      nxt[touch_way*CNT_W +: CNT_W] = row_o[touch_way*CNT_W +: CNT_W] + 1'b1;
  end

  always_comb begin
    victim_o = '0;
    best_c   = row_o[CNT_W-1:0];
    for (int w = 1; w < WAYS; w++) begin
      if (row_o[w*CNT_W +: CNT_W] < best_c) begin
        best_c   = row_o[w*CNT_W +: CNT_W];
        victim_o = RW'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) mem[s] <= '0;
    end else if (fill || touch) begin
      mem[set_idx] <= nxt;
    end
  end
endmodule

// File: rtl/repl_clock_store.sv
// Per-set reference bits and sweep pointer for second-chance replacement.
module repl_clock_store #(
  parameter int WAYS = 4,
  parameter int SETS = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(SETS)-1:0]     set_idx,
  input  logic                        touch,
  input  logic [$clog2(WAYS)-1:0]     touch_way,
  input  logic                        fill,
  input  logic [$clog2(WAYS)-1:0]     fill_way,
  output logic [WAYS-1:0]             refs_o,
  output logic [$clog2(WAYS)-1:0]     ptr_o,
  output logic [$clog2(WAYS)-1:0]     victim_o
);
  localparam int RW = $clog2(WAYS);

  logic [WAYS-1:0] refm [SETS];
  logic [RW-1:0]   ptrm [SETS];
  logic [WAYS-1:0] nrefs;
  logic [RW-1:0]   fill_dist;
  logic            found;

  assign refs_o    = refm[set_idx];
  assign ptr_o     = ptrm[set_idx];
  assign fill_dist = fill_way - ptr_o;

  always_comb begin
    victim_o = ptr_o;
    found    = 1'b0;
    for (int d = 0; d < WAYS; d++) begin
      if (!found && !refs_o[RW'(ptr_o + RW'(d))]) begin
        victim_o = RW'(ptr_o + RW'(d));
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    nrefs = refs_o;
    if (fill) begin
      for (int w = 0; w < WAYS; w++) begin
        if (&refs_o || (RW'(RW'(w) - ptr_o) < fill_dist)) nrefs[w] = 1'b0;
      end
      nrefs[fill_way] = 1'b1;
    end else if (touch) begin
      nrefs[touch_way] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        refm[s] <= '0;
        ptrm[s] <= '0;
      end
    end else begin
      if (fill || touch) refm[set_idx] <= nrefs;
      if (fill)          ptrm[set_idx] <= fill_way + 1'b1;
    end
  end
endmodule

// File: rtl/repl_lfsr.sv
// Free-running 16-bit Fibonacci LFSR, taps 16/14/13/11.
module repl_lfsr #(
  parameter int          PICK_W = 2,
  parameter logic [15:0] SEED   = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PICK_W-1:0] pick_o
);
  logic [15:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
  end

  assign pick_o = q[PICK_W-1:0];
endmodule

// File: rtl/repl_select.sv
module repl_select
  import repl_pkg::*;
#(
  parameter int          WAYS      = 4,
  parameter int          SETS      = 16,
  parameter int          CNT_W     = 4,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [2:0]                  policy,
  input  logic [$clog2(SETS)-1:0]     set_idx,
  input  logic                        touch,
  input  logic [$clog2(WAYS)-1:0]     touch_way,
  input  logic                        fill,
  input  logic [$clog2(WAYS)-1:0]     fill_way,
  output logic [$clog2(WAYS)-1:0]     victim_o,
  output logic [WAYS*CNT_W-1:0]       state_o,
  output logic [$clog2(WAYS)-1:0]     ptr_o
);
  localparam int RW = $clog2(WAYS);

  logic [WAYS*RW-1:0]    rec_row, arr_row;
  logic [RW-1:0]         rec_old, rec_new, arr_old, arr_new;
  logic [WAYS*CNT_W-1:0] cnt_row;
  logic [RW-1:0]         lfu_vic, clk_vic, clk_ptr, rnd_vic;
  logic [WAYS-1:0]       ref_row;
  logic                  rec_upd;
  logic [RW-1:0]         rec_way;
  logic [RW-1:0]         vic_c;
  logic [WAYS*CNT_W-1:0] disp_c;
  repl_pol_e             pol;

  assign pol     = repl_pol_e'(policy);
  assign rec_upd = touch | fill;
  assign rec_way = fill ? fill_way : touch_way;

  repl_rank_store #(.WAYS(WAYS), .SETS(SETS)) u_recency (
    .clk(clk), .rst(rst), .set_idx(set_idx), .upd(rec_upd), .upd_way(rec_way),
    .row_o(rec_row), .oldest_o(rec_old), .newest_o(rec_new)
  );

  repl_rank_store #(.WAYS(WAYS), .SETS(SETS)) u_arrival (
    .clk(clk), .rst(rst), .set_idx(set_idx), .upd(fill), .upd_way(fill_way),
    .row_o(arr_row), .oldest_o(arr_old), .newest_o(arr_new)
  );

  repl_lfu_store #(.WAYS(WAYS), .SETS(SETS), .CNT_W(CNT_W)) u_lfu (
    .clk(clk), .rst(rst), .set_idx(set_idx), .touch(touch), .touch_way(touch_way),
    .fill(fill), .fill_way(fill_way), .row_o(cnt_row), .victim_o(lfu_vic)
  );

  repl_clock_store #(.WAYS(WAYS), .SETS(SETS)) u_clock (
    .clk(clk), .rst(rst), .set_idx(set_idx), .touch(touch), .touch_way(touch_way),
    .fill(fill), .fill_way(fill_way), .refs_o(ref_row), .ptr_o(clk_ptr),
    .victim_o(clk_vic)
  );

  repl_lfsr #(.PICK_W(RW), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .pick_o(rnd_vic)
  );

  // Victim and display selection; unassigned codes fall back to recency.
  always_comb begin
    case (pol)
      POL_FIFO:  vic_c = arr_old;
      POL_MRU:   vic_c = rec_new;
      POL_LFU:   vic_c = lfu_vic;
      POL_CLOCK: vic_c = clk_vic;
      POL_RAND:  vic_c = rnd_vic;
      default:   vic_c = rec_old;
    endcase
    for (int w = 0; w < WAYS; w++) begin
      case (pol)
        POL_FIFO:  disp_c[w*CNT_W +: CNT_W] = CNT_W'(arr_row[w*RW +: RW]);
        POL_LFU:   disp_c[w*CNT_W +: CNT_W] = cnt_row[w*CNT_W +: CNT_W];
        POL_CLOCK: disp_c[w*CNT_W +: CNT_W] = CNT_W'(ref_row[w]);
        POL_RAND:  disp_c[w*CNT_W +: CNT_W] = '0;
        default:   disp_c[w*CNT_W +: CNT_W] = CNT_W'(rec_row[w*RW +: RW]);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      victim_o <= '0;
      state_o  <= '0;
      ptr_o    <= '0;
    end else begin
      victim_o <= vic_c;
      state_o  <= disp_c;
      ptr_o    <= clk_ptr;
    end
  end
endmodule

// File: rtl/repl_select_chk.sv
module repl_select_chk #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int CNT_W = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic [2:0]                  policy,
  input logic [$clog2(SETS)-1:0]     set_idx,
  input logic [$clog2(WAYS)-1:0]     victim_o,
  input logic [WAYS*CNT_W-1:0]       state_o,
  input logic [$clog2(WAYS)-1:0]     ptr_o
);
  logic [CNT_W-1:0] vf;
  logic [CNT_W-1:0] minc;
  logic             any_clear;

  assign vf = state_o[victim_o*CNT_W +: CNT_W];

  always_comb begin
    minc      = state_o[CNT_W-1:0];
    any_clear = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (state_o[w*CNT_W +: CNT_W] < minc) minc = state_o[w*CNT_W +: CNT_W];
      if (!state_o[w*CNT_W]) any_clear = 1'b1;
    end
  end

  assert_lru_oldest_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(policy) == 3'd0) |-> vf == CNT_W'(WAYS - 1));

  assert_mru_newest_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(policy) == 3'd2) |-> vf == '0);

  assert_lfu_min_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(policy) == 3'd3) |-> vf == minc);

  assert_clock_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(policy) == 3'd4 && any_clear) |-> !vf[0]);

  assert_reset_zero_R10: assert property (@(posedge clk)
    rst |=> (victim_o == '0 && ptr_o == '0 && state_o == '0));
endmodule

bind repl_select repl_select_chk #(.WAYS(WAYS), .SETS(SETS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .policy(policy), .set_idx(set_idx),
  .victim_o(victim_o), .state_o(state_o), .ptr_o(ptr_o)
);

// File: tb/repl_select_tb.sv
module repl_select_tb;
  localparam int          WAYS = 4;
  localparam int          SETS = 4;
  localparam int          CW   = 3;
  localparam logic [15:0] SEED = 16'hACE1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] policy = '0;
  logic [1:0] set_idx = '0;
  logic       touch = 1'b0, fill = 1'b0;
  logic [1:0] touch_way = '0, fill_way = '0;
  logic [1:0] victim_o, ptr_o;
  logic [WAYS*CW-1:0] state_o;

  int checks = 0, errors = 0;
  int rec [SETS][WAYS];
  int arr [SETS][WAYS];
  int cnt [SETS][WAYS];
  int rf  [SETS][WAYS];
  int ptr [SETS];
  logic [15:0] ml;
  int unsigned lcg = 32'd7;

  always #4 clk = ~clk;

  repl_select #(.WAYS(WAYS), .SETS(SETS), .CNT_W(CW), .LFSR_SEED(SEED)) u_dut (
    .clk(clk), .rst(rst), .policy(policy), .set_idx(set_idx), .touch(touch),
    .touch_way(touch_way), .fill(fill), .fill_way(fill_way),
    .victim_o(victim_o), .state_o(state_o), .ptr_o(ptr_o)
  );

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd(input int n);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 16) % n);
  endfunction

  task automatic age(ref int a [SETS][WAYS], input int s, input int way);
    int r = a[s][way];
    for (int w = 0; w < WAYS; w++) begin
      if (w == way) a[s][w] = 0;
      else if (a[s][w] < r) a[s][w] = a[s][w] + 1;
    end
  endtask

  // One cycle: drive, predict from pre-edge model, update model, compare.
  task automatic cyc(input int pol, input int s, input int t, input int tw,
                     input int f, input int fw);
    int ev, ep, ed, bc, allset, df;
    string tag;
    policy = 3'(pol); set_idx = 2'(s);
    touch = t[0]; touch_way = 2'(tw); fill = f[0]; fill_way = 2'(fw);
    ev = 0; ed = 0; ep = ptr[s];
    for (int w = 0; w < WAYS; w++) begin
      int fv;
      case (pol)
        1: fv = arr[s][w];
        3: fv = cnt[s][w];
        4: fv = rf[s][w];
        5: fv = 0;
        default: fv = rec[s][w];
      endcase
      ed = ed | (fv << (w * CW));
    end
    case (pol)
      1: begin for (int w = 0; w < WAYS; w++) if (arr[s][w] == WAYS-1) ev = w; tag = "R2"; end
      2: begin for (int w = 0; w < WAYS; w++) if (rec[s][w] == 0) ev = w; tag = "R3"; end
      3: begin
        bc = cnt[s][0];
        for (int w = 1; w < WAYS; w++) if (cnt[s][w] < bc) begin bc = cnt[s][w]; ev = w; end
        tag = "R4";
      end
      4: begin
        ev = ptr[s];
        for (int d = WAYS-1; d >= 0; d--) if (rf[s][(ptr[s]+d)%WAYS] == 0) ev = (ptr[s]+d)%WAYS;
        tag = "R5";
      end
      5: begin ev = int'(ml[1:0]); tag = "R7"; end
      0: begin for (int w = 0; w < WAYS; w++) if (rec[s][w] == WAYS-1) ev = w; tag = "R1"; end
      default: begin for (int w = 0; w < WAYS; w++) if (rec[s][w] == WAYS-1) ev = w; tag = "R11"; end
    endcase
    if (t != 0 && f != 0) tag = {tag, " R9"};
    @(posedge clk);
    #1;
    if (f != 0) begin
      age(rec, s, fw);
      age(arr, s, fw);
      cnt[s][fw] = 1;
      allset = 1;
      for (int w = 0; w < WAYS; w++) if (rf[s][w] == 0) allset = 0;
      df = (fw - ptr[s] + WAYS) % WAYS;
      for (int w = 0; w < WAYS; w++)
        if (allset != 0 || ((w - ptr[s] + WAYS) % WAYS) < df) rf[s][w] = 0;
      rf[s][fw] = 1;
      ptr[s] = (fw + 1) % WAYS;
    end else if (t != 0) begin
      age(rec, s, tw);
      if (cnt[s][tw] < (1 << CW) - 1) cnt[s][tw] = cnt[s][tw] + 1;
      rf[s][tw] = 1;
    end
    ml = {ml[14:0], ml[15] ^ ml[13] ^ ml[12] ^ ml[10]};
    @(negedge clk);
    chk({tag, " victim"}, int'(victim_o), ev);
    chk("R8 state", int'(state_o), ed);
    chk("R6 pointer", int'(ptr_o), ep);
  endtask

  initial begin
    for (int s = 0; s < SETS; s++) begin
      ptr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        rec[s][w] = w; arr[s][w] = w; cnt[s][w] = 0; rf[s][w] = 0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    ml  = SEED;
    chk("R10 victim after reset", int'(victim_o), 0);
    chk("R10 state after reset", int'(state_o), 0);
    chk("R10 pointer after reset", int'(ptr_o), 0);

    // R10: ranks start in way order (LRU display of set 3, idle cycle).
    cyc(0, 3, 0, 0, 0, 0);
    chk("R10 initial ranks", int'(state_o), (3 << 9) | (2 << 6) | (1 << 3));

    // R4: saturation and tie-break directed run on set 2.
    for (int i = 0; i < 12; i++) cyc(3, 2, 1, 1, 0, 0);
    for (int i = 0; i < 3; i++) cyc(3, 2, 1, 2, 0, 0);
    cyc(3, 2, 0, 0, 0, 0);

    // R5/R6: saturate every reference bit of set 1, then sweep.
    for (int w = 0; w < WAYS; w++) cyc(4, 1, 1, w, 0, 0);
    cyc(4, 1, 0, 0, 1, 2);
    cyc(4, 1, 1, 0, 0, 0);
    cyc(4, 1, 0, 0, 1, 1);
    cyc(4, 1, 0, 0, 0, 0);

    // R9: simultaneous strobes on distinct ways.
    cyc(0, 0, 1, 3, 1, 0);
    cyc(0, 0, 0, 0, 0, 0);

    // Sweeps over every policy code, history carried across switches (R11).
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < 220; i++) begin
        int t = (rnd(4) != 0) ? 1 : 0;
        int f = (rnd(4) == 0) ? 1 : 0;
        cyc(p, rnd(SETS), t, rnd(WAYS), f, rnd(WAYS));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule